// File: doc/BRIEF.md
# PCI Target Latency Timeout Monitor

This block sits beside a PCI target state machine and watches each transaction the target accepts. When the back end takes too long to supply data, it asks the target to end the bus cycle. Two intervals are timed. The first runs from the address phase to the first data strobe. The second runs between consecutive data strobes inside a burst. Each interval has its own selectable limit. When a limit runs out, the block emits a one-clock terminate request. The target logic turns that request into a retry or a disconnect on the bus.

A second, independent timer measures how long the bus has been held. It raises a tenure-expired flag once the hold time reaches a programmed count, with that count rounded down to a multiple of eight.

All limits are sampled when a transaction starts. Configuration writes that land during a transaction therefore apply only from the next transaction on.

Top module: `pci_lat_monitor`

## Requirements
- R1: After a `cyc_start` sample with no `data_valid` sampled at any of the next L rising edges, `terminate` is high for the cycle following the L-th edge. L comes from `init_sel`: 2'b00 gives 32, 2'b01 gives 16, 2'b10 gives 8, 2'b11 gives 4.
- R2: A `data_valid` sampled at any edge from the 1st to the L-th after `cyc_start` suppresses the initial timeout and moves the monitor into the burst phase. No terminate follows it in the next cycle.
- R3: In the burst phase, every sampled `data_valid` restarts the interval. When no `data_valid` is sampled for M consecutive edges, `terminate` is high for the cycle after the M-th edge. M is 8 when `sub_sel` is 0 and 4 when it is 1.
- R4: `terminate` is high for exactly one cycle. After it, the monitor is idle, and no further terminate occurs until the next `cyc_start`, even when `data_valid` toggles.
- R5: A `burst_end` sampled while a transaction is being timed stops the timing without a terminate. No terminate follows until the next `cyc_start`.
- R6: `init_sel`, `sub_sel` and `usage_limit` are sampled only at an edge where `cyc_start` is high. Changes made at other times have no effect on the transaction in progress.
- R7: While `bus_owned` stays high, `tenure_expired` goes high after the N-th owned edge and stays high. N is the latched `usage_limit` with bits [2:0] forced to zero, so N=0 asserts it after the first owned edge.
- R8: `tenure_expired` is low in the cycle after any edge that samples `bus_owned` low. The tenure count then restarts from zero.
- R9: While `rst_n` is sampled low, `terminate` and `tenure_expired` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Address-phase pulse that opens a transaction and samples configuration |
| data_valid | input | 1 | Back end has data ready for the current data phase |
| burst_end | input | 1 | Current transaction has finished |
| bus_owned | input | 1 | Bus is held; the tenure timer counts while high |
| init_sel | input | 2 | First-data-phase limit select |
| sub_sel | input | 1 | Burst data-phase limit select |
| usage_limit | input | 8 | Tenure limit; bits [2:0] are ignored |
| terminate | output | 1 | One-cycle request to end the bus cycle |
| tenure_expired | output | 1 | Bus hold time has reached the tenure limit |

## Verification
The hardest cases to reach are the exact boundary edges: a first strobe that arrives on the very last allowed edge, and a burst strobe that arrives on the last allowed edge of its interval. An off-by-one slip in either counter shows only there. The bench therefore sweeps every strobe position from the first edge to the limit, for every initial select. After each swept position it lets the burst interval expire under both subsequent selects. This pins both counters at both ends of their range. A set of tenure limits whose low bits are nonzero checks the masking. A configuration change made in mid-transaction checks the sampling at start.

// File: rtl/pci_lat_pkg.sv
// Package: shared phase type and limit decode for the latency monitor.
// Assumes limits are powers of two, halved per step of the select code.
package pci_lat_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INIT  = 2'd1,
        PH_BURST = 2'd2
    } lat_phase_e;

    // Limit for a select code: the largest limit halved once per code step.
    function automatic int unsigned limit_for(input int unsigned max_lim,
                                              input int unsigned code);
        return max_lim >> code;
    endfunction

endpackage

// File: rtl/pci_lat_phase_timer.sv
// Module: times the address-to-first-data interval and the gaps between
// burst data phases, and pulses term when the active limit runs out.
// Assumes cyc_start marks a new transaction, takes priority over all else,
// and is the only point where the limit selects are sampled.
module pci_lat_phase_timer
    import pci_lat_pkg::*;
#(
    parameter int unsigned INIT_MAX = 32,
    parameter int unsigned SUB_MAX  = 8,
    parameter int unsigned ISEL_W   = 2,
    parameter int unsigned SSEL_W   = 1,
    localparam int unsigned CNT_W   = $clog2(INIT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              data_valid,
    input  logic              burst_end,
    input  logic [ISEL_W-1:0] init_sel,
    input  logic [SSEL_W-1:0] sub_sel,
    output logic              term
);

    lat_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] init_lim_q;
    logic [CNT_W-1:0] sub_lim_q;
    logic [CNT_W-1:0] cur_lim;
    logic             term_q;

    // Select the limit that applies to the current phase.
    always_comb begin
        cur_lim = (phase_q == PH_INIT) ? init_lim_q : sub_lim_q;
    end

    // Phase tracking, interval counting and the terminate pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            init_lim_q <= CNT_W'(INIT_MAX);
            sub_lim_q  <= CNT_W'(SUB_MAX);
            term_q     <= 1'b0;
        end else begin
            term_q <= 1'b0;
            if (cyc_start) begin
                phase_q    <= PH_INIT;
                cnt_q      <= '0;
                init_lim_q <= CNT_W'(limit_for(INIT_MAX, int'(init_sel)));
                sub_lim_q  <= CNT_W'(limit_for(SUB_MAX, int'(sub_sel)));
            end else if (phase_q != PH_IDLE) begin
                if (burst_end) begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end else if (data_valid) begin
                    phase_q <= PH_BURST;
                    cnt_q   <= '0;
                end else if (cnt_q == cur_lim - CNT_W'(1)) begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                    term_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign term = term_q;

    // R4: the request never lasts longer than one cycle.
    p_term_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        term_q |=> !term_q);

    // R1, R3: the running count stays below the active limit.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |-> (cnt_q < cur_lim));

    // R2: a strobe during timing is never followed by a terminate.
    p_dv_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && phase_q != PH_IDLE) |=> !term_q);

    // R5: a sampled end of burst is never followed by a terminate.
    p_end_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |=> !term_q);

    // R6: the latched limits change only when a transaction starts.
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> ($stable(init_lim_q) && $stable(sub_lim_q)));

endmodule

// File: rtl/pci_lat_tenure_timer.sv
// Module: counts the edges for which the bus is held and flags when the
// count reaches the tenure limit, whose low bits are forced to zero.
// Assumes the limit is sampled at cyc_start. The count saturates at its
// maximum so the flag cannot wrap back low.
module pci_lat_tenure_timer #(
    parameter int unsigned USAGE_W  = 8,
    parameter int unsigned ZERO_LSB = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic               bus_owned,
    input  logic [USAGE_W-1:0] usage_limit,
    output logic               expired
);

    logic [USAGE_W-1:0] lim_q;
    logic [USAGE_W-1:0] cnt_q;
    logic               own_q;

    // Sample the tenure limit with its low bits dropped at transaction start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else if (cyc_start) begin
            lim_q <= {usage_limit[USAGE_W-1:ZERO_LSB], {ZERO_LSB{1'b0}}};
        end
    end

    // Saturating count of held edges; it clears when the bus is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            own_q <= 1'b0;
        end else begin
            own_q <= bus_owned;
            if (!bus_owned) begin
                cnt_q <= '0;
            end else if (cnt_q != {USAGE_W{1'b1}}) begin
                cnt_q <= cnt_q + USAGE_W'(1);
            end
        end
    end

    assign expired = own_q && (cnt_q >= lim_q);

    // R8: releasing the bus drops the flag in the next cycle.
    p_release_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_owned |=> !expired);

    // R7: once raised, the flag holds while the bus stays held.
    p_expired_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && bus_owned && !cyc_start) |=> expired);

    // R6: the tenure limit is sampled only at transaction start.
    p_lim_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(lim_q));

endmodule

// File: rtl/pci_lat_monitor.sv
// Module: top of the PCI target latency monitor. It joins the data-phase
// timer and the bus tenure timer.
// Assumes all inputs are synchronous to clk and that the target state
// machine acts on the one-cycle terminate request.
module pci_lat_monitor #(
    parameter int unsigned INIT_MAX = 32,
    parameter int unsigned SUB_MAX  = 8,
    parameter int unsigned USAGE_W  = 8,
    parameter int unsigned ZERO_LSB = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic               data_valid,
    input  logic               burst_end,
    input  logic               bus_owned,
    input  logic [1:0]         init_sel,
    input  logic               sub_sel,
    input  logic [USAGE_W-1:0] usage_limit,
    output logic               terminate,
    output logic               tenure_expired
);

    // Data-phase latency timing.
    pci_lat_phase_timer #(
        .INIT_MAX (INIT_MAX),
        .SUB_MAX  (SUB_MAX),
        .ISEL_W   (2),
        .SSEL_W   (1)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start  (cyc_start),
        .data_valid (data_valid),
        .burst_end  (burst_end),
        .init_sel   (init_sel),
        .sub_sel    (sub_sel),
        .term       (terminate)
    );

    // Bus tenure timing.
    pci_lat_tenure_timer #(
        .USAGE_W  (USAGE_W),
        .ZERO_LSB (ZERO_LSB)
    ) u_tenure (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .bus_owned   (bus_owned),
        .usage_limit (usage_limit),
        .expired     (tenure_expired)
    );

    // R9: both outputs are low during reset.
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (!terminate && !tenure_expired));

endmodule

// File: tb/pci_lat_monitor_test.sv
`timescale 1ns/1ps
module pci_lat_monitor_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic       data_valid = 1'b0;
    logic       burst_end = 1'b0;
    logic       bus_owned = 1'b0;
    logic [1:0] init_sel = 2'b00;
    logic       sub_sel = 1'b0;
    logic [7:0] usage_limit = 8'h00;
    logic       terminate;
    logic       tenure_expired;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pci_lat_monitor uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cyc_start      (cyc_start),
        .data_valid     (data_valid),
        .burst_end      (burst_end),
        .bus_owned      (bus_owned),
        .init_sel       (init_sel),
        .sub_sel        (sub_sel),
        .usage_limit    (usage_limit),
        .terminate      (terminate),
        .tenure_expired (tenure_expired)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic begin_txn(input logic [1:0] is, input logic ss, input logic [7:0] ul);
        cyc_start = 1'b1;
        init_sel = is;
        sub_sel = ss;
        usage_limit = ul;
        tick();
        cyc_start = 1'b0;
    endtask

    // No strobes for lim edges: the pulse appears after the last edge, for one cycle only.
    task automatic expect_timeout(input int lim, input string req);
        for (int i = 1; i < lim; i++) begin
            tick();
            check(req, terminate, 1'b0);
        end
        tick();
        check(req, terminate, 1'b1);
        tick();
        check("R4", terminate, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", terminate, 1'b0);
        check("R9", tenure_expired, 1'b0);
        rst_n = 1'b1;
        tick();

        // R1: the initial limit for each select code.
        for (int is = 0; is < 4; is++) begin
            begin_txn(2'(is), 1'b0, 8'h00);
            expect_timeout(32 >> is, "R1");
        end

        // R4: idle after a terminate; strobes alone start nothing.
        for (int i = 0; i < 40; i++) begin
            data_valid = (i % 3 == 0);
            tick();
            check("R4", terminate, 1'b0);
        end
        data_valid = 1'b0;

        // R2, R3: every strobe position, then the burst interval expires.
        for (int is = 0; is < 4; is++) begin
            for (int ss = 0; ss < 2; ss++) begin
                for (int d = 1; d <= (32 >> is); d++) begin
                    begin_txn(2'(is), 1'(ss), 8'h00);
                    for (int i = 1; i <= d; i++) begin
                        data_valid = (i == d);
                        tick();
                        check("R2", terminate, 1'b0);
                    end
                    data_valid = 1'b0;
                    expect_timeout(8 >> ss, "R3");
                end
            end
        end

        // R3: strobes on the last allowed edge keep restarting the interval.
        begin_txn(2'b11, 1'b1, 8'h00);
        data_valid = 1'b1;
        tick();
        data_valid = 1'b0;
        for (int r = 0; r < 5; r++) begin
            for (int i = 1; i <= 4; i++) begin
                data_valid = (i == 4);
                tick();
                check("R3", terminate, 1'b0);
            end
        end
        data_valid = 1'b0;
        // R5: the burst ends, and no terminate follows.
        burst_end = 1'b1;
        tick();
        burst_end = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tick();
            check("R5", terminate, 1'b0);
        end

        // R5: the transaction ends during the initial phase.
        begin_txn(2'b00, 1'b0, 8'h00);
        repeat (5) tick();
        burst_end = 1'b1;
        tick();
        burst_end = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tick();
            check("R5", terminate, 1'b0);
        end

        // R6: a mid-transaction select change is ignored (initial limit).
        begin_txn(2'b11, 1'b1, 8'h00);
        init_sel = 2'b00;
        sub_sel = 1'b0;
        expect_timeout(4, "R6");
        // R6: the same for the burst limit.
        begin_txn(2'b00, 1'b1, 8'h00);
        sub_sel = 1'b0;
        data_valid = 1'b1;
        tick();
        data_valid = 1'b0;
        expect_timeout(4, "R6");

        // R7, R8: tenure limits, low bits set in some of them.
        for (int k = 0; k < 7; k++) begin
            logic [7:0] ul;
            int n;
            case (k)
                0: ul = 8'h05;
                1: ul = 8'h08;
                2: ul = 8'h0F;
                3: ul = 8'h10;
                4: ul = 8'h2B;
                5: ul = 8'h80;
                default: ul = 8'hFF;
            endcase
            n = int'(ul & 8'hF8);
            begin_txn(2'b00, 1'b0, ul);
            burst_end = 1'b1;
            tick();
            burst_end = 1'b0;
            usage_limit = 8'h00;  // R6: ignored until the next start
            bus_owned = 1'b1;
            for (int i = 1; i <= n + 3; i++) begin
                tick();
                check("R7", tenure_expired, (i >= n) ? 1'b1 : 1'b0);
            end
            bus_owned = 1'b0;
            tick();
            check("R8", tenure_expired, 1'b0);
        end

        // R8: a release in mid-count restarts the count.
        begin_txn(2'b00, 1'b0, 8'h10);
        burst_end = 1'b1;
        tick();
        burst_end = 1'b0;
        bus_owned = 1'b1;
        repeat (10) tick();
        bus_owned = 1'b0;
        tick();
        check("R8", tenure_expired, 1'b0);
        bus_owned = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            tick();
            check("R8", tenure_expired, (i >= 16) ? 1'b1 : 1'b0);
        end
        bus_owned = 1'b0;
        tick();

        // R9: reset in mid-activity clears both outputs.
        bus_owned = 1'b1;
        rst_n = 1'b0;
        tick();
        check("R9", terminate, 1'b0);
        check("R9", tenure_expired, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule